// File: doc/BRIEF.md
# FIFO Pointer Reset and Rewind Controller

This block owns the read and write pointers of a synchronous FIFO. Around them it handles two kinds of reset and a replay request. A master reset returns the whole block to its starting state and loads the configuration registers from their selection inputs. A partial reset clears only the two pointers and leaves the stored configuration as it was. A rewind request moves the read pointer back to address zero, so the words written since the last reset can be read out a second time. The write pointer is not touched by a rewind.

The rewind runs in one of two latencies, chosen by a configuration bit that is captured during master reset. In zero-latency mode the read pointer is back at zero on the cycle after the request. In delayed mode the read pointer is also rewound at once, but reads are held off and the empty output stays high for a fixed number of clocks. The memory array, the width conversion and the threshold comparisons sit outside this block. It only supplies the pointers, the fill level, the held configuration, and a one-cycle pointer-reset strobe for the flag logic.

Top module: `fifo_rewind_ctrl`

## Requirements
- R1: While `mst_rst` is high, at every clock both pointers and `level_o` go to 0, `empty_o` goes to 1, `full_o` and `rt_busy_o` go to 0, and `ptr_clr_o` goes to 1.
- R2: On every clock where `mst_rst` is high, the held configuration (`cfg_off_o`, `cfg_wide_o`, `cfg_rtdly_o`) copies the inputs `cfg_off_i`, `cfg_wide_i` and `cfg_rtdly_i`. On any other clock it keeps its value whatever those inputs do.
- R3: A clock with `ptr_rst` high and `mst_rst` low sets both pointers and `level_o` to 0, clears `rt_busy_o`, sets `ptr_clr_o` for the following cycle, and leaves the held configuration unchanged.
- R4: A write is taken when `wr_en` is high and `full_o` is low. A read is taken when `rd_en` is high, `empty_o` is low and no rewind is taken on the same clock. Each taken access moves its address up by one, modulo 2**ADDR_W. `level_o` equals writes minus reads.
- R5: `full_o` is high exactly when `level_o` equals 2**ADDR_W (16 by default). In that state, `wr_en` changes neither the write address nor `level_o`.
- R6: With `cfg_rtdly_o`=0, a rewind taken on a clock gives `rd_addr_o`=0 and `ptr_clr_o`=1 in the next cycle, with `rt_busy_o`=0. A read requested on that clock is dropped, and a write on that clock still advances the write pointer. `level_o` then equals the number of words written since the last reset.
- R7: With `cfg_rtdly_o`=1, a taken rewind sets `rd_addr_o` to 0. It then holds `rt_busy_o` and `empty_o` high for exactly RT_DLY cycles (3 by default), during which reads and further rewind requests are ignored.
- R8: A rewind request while `level_o` is 0 is ignored. The read address keeps its value, `rt_busy_o` stays low and `ptr_clr_o` stays low.
- R9: Master reset overrides partial reset, and partial reset overrides a rewind request on the same clock.
- R10: `level_o` never exceeds 2**ADDR_W while no more than 2**ADDR_W words have been written since the last reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| mst_rst | input | 1 | Synchronous master reset, active high |
| ptr_rst | input | 1 | Synchronous pointer-only reset, active high |
| cfg_off_i | input | OFF_W | Flag offset selection, captured during master reset |
| cfg_wide_i | input | 1 | Port width selection, captured during master reset |
| cfg_rtdly_i | input | 1 | Rewind latency selection (0 zero-latency, 1 delayed), captured during master reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| rt_req | input | 1 | Rewind request |
| wr_addr_o | output | ADDR_W | Write address |
| rd_addr_o | output | ADDR_W | Read address |
| level_o | output | ADDR_W+1 | Words available to read |
| empty_o | output | 1 | No readable word, or delayed rewind in progress |
| full_o | output | 1 | Storage full |
| rt_busy_o | output | 1 | Delayed rewind window active |
| ptr_clr_o | output | 1 | Pointers were reset or rewound on the previous clock |
| cfg_off_o | output | OFF_W | Held flag offset |
| cfg_wide_o | output | 1 | Held width selection |
| cfg_rtdly_o | output | 1 | Held rewind latency selection |

## Verification
The case hardest to reach from the ports is the end of a delayed rewind window. Reads, further rewind requests and a pending write all meet there while the busy counter is still nonzero. Only the captured latency bit selects that path, so the stimulus first performs a master reset with the delayed setting. It then fills the FIFO to capacity and drains part of it. Next it issues a rewind and keeps both `rd_en` and `rt_req` high through the whole window. A read that leaks through or a restarted window then shows up as a moved read address or a busy output that lasts too long. Partial reset is tested with changed selection inputs, so that any configuration loss is visible on the held outputs.

// File: rtl/fifo_rw_pkg.sv
package fifo_rw_pkg;
   typedef enum logic {
      RT_ZERO    = 1'b0,
      RT_DELAYED = 1'b1
   } rt_mode_e;
endpackage

// File: rtl/frc_cfg_hold.sv
module frc_cfg_hold #(
   parameter int OFF_W = 4
) (
   input  logic                   clk,
   input  logic                   mst_rst,
   input  logic [OFF_W-1:0]       off_i,
   input  logic                   wide_i,
   input  fifo_rw_pkg::rt_mode_e  mode_i,
   output logic [OFF_W-1:0]       off_q,
   output logic                   wide_q,
   output fifo_rw_pkg::rt_mode_e  mode_q
);
   always_ff @(posedge clk) begin
      if (mst_rst) begin
         off_q  <= off_i;
         wide_q <= wide_i;
         mode_q <= mode_i;
      end
   end

   AST_CFG_HELD: assert property (@(posedge clk) disable iff (mst_rst)
      !$past(mst_rst) |-> ($stable(off_q) && $stable(wide_q) && $stable(mode_q))); // R2
endmodule

// File: rtl/frc_ptr_ctrl.sv
module frc_ptr_ctrl #(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              mst_rst,
   input  logic              ptr_rst,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              rewind,
   input  logic              hold,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [ADDR_W:0]   level,
   output logic              is_empty,
   output logic              is_full
);
   localparam int PTR_W = ADDR_W + 1;
   localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

   logic [PTR_W-1:0] wr_q, rd_q;
   logic wr_take, rd_take;

   assign level    = wr_q - rd_q;
   assign is_empty = (level == '0);
   assign is_full  = (level == DEPTH_P);
   assign wr_take  = wr_en & ~is_full;
   assign rd_take  = rd_en & ~is_empty & ~hold & ~rewind;
   assign wr_addr  = wr_q[ADDR_W-1:0];
   assign rd_addr  = rd_q[ADDR_W-1:0];

   always_ff @(posedge clk) begin
      if (mst_rst || ptr_rst) begin
         wr_q <= '0;
         rd_q <= '0;
      end else begin
         if (wr_take) wr_q <= wr_q + 1'b1;
         if (rewind)       rd_q <= '0;
         else if (rd_take) rd_q <= rd_q + 1'b1;
      end
   end

   AST_MRST_CLEARS: assert property (@(posedge clk) disable iff (mst_rst)
      $past(mst_rst) |-> (wr_q == '0 && rd_q == '0)); // R1
   AST_PRST_CLEARS: assert property (@(posedge clk) disable iff (mst_rst)
      ($past(ptr_rst) && !$past(mst_rst)) |-> (wr_q == '0 && rd_q == '0)); // R3
   AST_REWIND_ZERO: assert property (@(posedge clk) disable iff (mst_rst || ptr_rst)
      rewind |=> (rd_q == '0)); // R6
   AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (mst_rst || ptr_rst)
      (hold && !rewind) |=> $stable(rd_q)); // R7
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (mst_rst)
      level <= DEPTH_P); // R10
   AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (mst_rst || ptr_rst)
      is_full |=> $stable(wr_q)); // R5
endmodule

// File: rtl/frc_rt_seq.sv
module frc_rt_seq #(
   parameter int RT_DLY = 3
) (
   input  logic                  clk,
   input  logic                  mst_rst,
   input  logic                  ptr_rst,
   input  logic                  rt_req,
   input  logic                  fifo_empty,
   input  fifo_rw_pkg::rt_mode_e mode,
   output logic                  rewind,
   output logic                  busy
);
   import fifo_rw_pkg::*;

   assign rewind = rt_req & ~mst_rst & ~ptr_rst & ~fifo_empty & ~busy;

   generate
      if (RT_DLY == 0) begin : g_no_window
         assign busy = 1'b0;
      end else begin : g_window
         localparam int CNT_W = $clog2(RT_DLY + 1);
         localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(RT_DLY);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (mst_rst || ptr_rst)                 cnt_q <= '0;
            else if (rewind && mode == RT_DELAYED)  cnt_q <= LOAD_V;
            else if (cnt_q != '0)                   cnt_q <= cnt_q - 1'b1;
         end
         assign busy = (cnt_q != '0);

         AST_WINDOW_OPENS: assert property (@(posedge clk) disable iff (mst_rst || ptr_rst)
            (rewind && mode == RT_DELAYED) |=> busy); // R7
         AST_ZERO_NO_WINDOW: assert property (@(posedge clk) disable iff (mst_rst || ptr_rst)
            (!busy && mode == RT_ZERO) |=> !busy); // R6
      end
   endgenerate

   AST_EMPTY_IGNORED: assert property (@(posedge clk) disable iff (mst_rst || ptr_rst)
      (rt_req && fifo_empty && !busy) |=> !busy); // R8
endmodule

// File: rtl/fifo_rewind_ctrl.sv
module fifo_rewind_ctrl #(
   parameter int ADDR_W = 4,
   parameter int OFF_W  = 4,
   parameter int RT_DLY = 3
) (
   input  logic              clk,
   input  logic              mst_rst,
   input  logic              ptr_rst,
   input  logic [OFF_W-1:0]  cfg_off_i,
   input  logic              cfg_wide_i,
   input  logic              cfg_rtdly_i,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              rt_req,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic [ADDR_W:0]   level_o,
   output logic              empty_o,
   output logic              full_o,
   output logic              rt_busy_o,
   output logic              ptr_clr_o,
   output logic [OFF_W-1:0]  cfg_off_o,
   output logic              cfg_wide_o,
   output logic              cfg_rtdly_o
);
   import fifo_rw_pkg::*;

   if (ADDR_W < 1 || ADDR_W > 24) begin : g_bad_addr_w
      $error("fifo_rewind_ctrl: ADDR_W out of range");
   end
   if (OFF_W < 1) begin : g_bad_off_w
      $error("fifo_rewind_ctrl: OFF_W must be positive");
   end
   if (RT_DLY < 0 || RT_DLY > 255) begin : g_bad_dly
      $error("fifo_rewind_ctrl: RT_DLY out of range");
   end

   rt_mode_e mode_q;
   logic     raw_empty, rewind, busy;

   frc_cfg_hold #(.OFF_W(OFF_W)) u_cfg (
      .clk    (clk),
      .mst_rst(mst_rst),
      .off_i  (cfg_off_i),
      .wide_i (cfg_wide_i),
      .mode_i (rt_mode_e'(cfg_rtdly_i)),
      .off_q  (cfg_off_o),
      .wide_q (cfg_wide_o),
      .mode_q (mode_q)
   );

   frc_rt_seq #(.RT_DLY(RT_DLY)) u_seq (
      .clk       (clk),
      .mst_rst   (mst_rst),
      .ptr_rst   (ptr_rst),
      .rt_req    (rt_req),
      .fifo_empty(raw_empty),
      .mode      (mode_q),
      .rewind    (rewind),
      .busy      (busy)
   );

   frc_ptr_ctrl #(.ADDR_W(ADDR_W)) u_ptr (
      .clk     (clk),
      .mst_rst (mst_rst),
      .ptr_rst (ptr_rst),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .rewind  (rewind),
      .hold    (busy),
      .wr_addr (wr_addr_o),
      .rd_addr (rd_addr_o),
      .level   (level_o),
      .is_empty(raw_empty),
      .is_full (full_o)
   );

   always_ff @(posedge clk) begin
      ptr_clr_o <= mst_rst | ptr_rst | rewind;
   end

   assign empty_o     = raw_empty | busy;
   assign rt_busy_o   = busy;
   assign cfg_rtdly_o = (mode_q == RT_DELAYED);

   AST_PRIO_MRST: assert property (@(posedge clk) disable iff (mst_rst)
      $past(mst_rst) |-> (!rt_busy_o && level_o == '0)); // R9
   AST_CLR_STROBE: assert property (@(posedge clk) disable iff (mst_rst)
      (ptr_rst && !mst_rst) |=> ptr_clr_o); // R3
endmodule

// File: tb/fifo_rewind_ctrl_tb.sv
module fifo_rewind_ctrl_tb;
   localparam int AW = 4;
   localparam int OW = 4;
   localparam int DLY = 3;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic mst_rst = 1'b1, ptr_rst = 1'b0;
   logic [OW-1:0] cfg_off_i = '0;
   logic cfg_wide_i = 1'b0, cfg_rtdly_i = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0, rt_req = 1'b0;
   logic [AW-1:0] wr_addr_o, rd_addr_o;
   logic [AW:0] level_o;
   logic empty_o, full_o, rt_busy_o, ptr_clr_o;
   logic [OW-1:0] cfg_off_o;
   logic cfg_wide_o, cfg_rtdly_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   fifo_rewind_ctrl #(.ADDR_W(AW), .OFF_W(OW), .RT_DLY(DLY)) u_dut (
      .clk(clk), .mst_rst(mst_rst), .ptr_rst(ptr_rst),
      .cfg_off_i(cfg_off_i), .cfg_wide_i(cfg_wide_i), .cfg_rtdly_i(cfg_rtdly_i),
      .wr_en(wr_en), .rd_en(rd_en), .rt_req(rt_req),
      .wr_addr_o(wr_addr_o), .rd_addr_o(rd_addr_o), .level_o(level_o),
      .empty_o(empty_o), .full_o(full_o), .rt_busy_o(rt_busy_o), .ptr_clr_o(ptr_clr_o),
      .cfg_off_o(cfg_off_o), .cfg_wide_o(cfg_wide_o), .cfg_rtdly_o(cfg_rtdly_o)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic master_reset(input int off, input bit wide, input bit dly);
      mst_rst = 1'b1; cfg_off_i = OW'(off); cfg_wide_i = wide; cfg_rtdly_i = dly;
      tick(); tick();
      chk("R1", "ptr_clr during reset", int'(ptr_clr_o), 1);
      mst_rst = 1'b0;
   endtask

   task automatic do_writes(input int n);
      wr_en = 1'b1;
      for (int i = 0; i < n; i++) tick();
      wr_en = 1'b0;
   endtask

   task automatic do_reads(input int n);
      rd_en = 1'b1;
      for (int i = 0; i < n; i++) tick();
      rd_en = 1'b0;
   endtask

   task automatic t_reset();
      master_reset(5, 1'b1, 1'b0);
      chk("R1", "wr_addr", int'(wr_addr_o), 0);
      chk("R1", "rd_addr", int'(rd_addr_o), 0);
      chk("R1", "level", int'(level_o), 0);
      chk("R1", "empty", int'(empty_o), 1);
      chk("R1", "full", int'(full_o), 0);
      chk("R1", "busy", int'(rt_busy_o), 0);
      chk("R2", "cfg_off captured", int'(cfg_off_o), 5);
      chk("R2", "cfg_wide captured", int'(cfg_wide_o), 1);
      chk("R2", "cfg_rtdly captured", int'(cfg_rtdly_o), 0);
      cfg_off_i = 4'd9; cfg_wide_i = 1'b0; cfg_rtdly_i = 1'b1;
      tick();
      chk("R2", "cfg_off held", int'(cfg_off_o), 5);
      chk("R2", "cfg_wide held", int'(cfg_wide_o), 1);
      chk("R2", "cfg_rtdly held", int'(cfg_rtdly_o), 0);
      chk("R1", "ptr_clr after release", int'(ptr_clr_o), 0);
   endtask

   task automatic t_write_read();
      do_writes(5);
      chk("R4", "wr_addr after 5 writes", int'(wr_addr_o), 5);
      chk("R4", "level after 5 writes", int'(level_o), 5);
      chk("R4", "empty with data", int'(empty_o), 0);
      do_reads(2);
      chk("R4", "rd_addr after 2 reads", int'(rd_addr_o), 2);
      chk("R4", "level after 2 reads", int'(level_o), 3);
   endtask

   task automatic t_zero_rewind();
      rt_req = 1'b1; rd_en = 1'b1; wr_en = 1'b1;
      tick();
      rt_req = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
      chk("R6", "rd_addr rewound", int'(rd_addr_o), 0);
      chk("R6", "wr_addr still advances", int'(wr_addr_o), 6);
      chk("R6", "level equals writes", int'(level_o), 6);
      chk("R6", "no busy", int'(rt_busy_o), 0);
      chk("R6", "empty low", int'(empty_o), 0);
      chk("R6", "ptr_clr pulse", int'(ptr_clr_o), 1);
      tick();
      chk("R6", "ptr_clr one cycle", int'(ptr_clr_o), 0);
      do_reads(1);
      chk("R6", "replay read advances", int'(rd_addr_o), 1);
   endtask

   task automatic t_partial();
      cfg_off_i = 4'd2; cfg_wide_i = 1'b0; cfg_rtdly_i = 1'b1;
      ptr_rst = 1'b1;
      tick();
      ptr_rst = 1'b0;
      chk("R3", "wr_addr cleared", int'(wr_addr_o), 0);
      chk("R3", "rd_addr cleared", int'(rd_addr_o), 0);
      chk("R3", "level cleared", int'(level_o), 0);
      chk("R3", "ptr_clr pulse", int'(ptr_clr_o), 1);
      chk("R3", "cfg_off kept", int'(cfg_off_o), 5);
      chk("R3", "cfg_wide kept", int'(cfg_wide_o), 1);
      chk("R3", "cfg_rtdly kept", int'(cfg_rtdly_o), 0);
      do_writes(2);
      rt_req = 1'b1;
      tick();
      rt_req = 1'b0;
      chk("R3", "mode kept: zero-latency rewind", int'(rt_busy_o), 0);
      chk("R3", "rewind after partial reset", int'(empty_o), 0);
   endtask

   task automatic t_empty_rewind();
      do_reads(2);
      chk("R8", "drained rd_addr", int'(rd_addr_o), 2);
      chk("R8", "drained level", int'(level_o), 0);
      rt_req = 1'b1;
      tick();
      rt_req = 1'b0;
      chk("R8", "rd_addr unchanged", int'(rd_addr_o), 2);
      chk("R8", "busy stays low", int'(rt_busy_o), 0);
      chk("R8", "no ptr_clr", int'(ptr_clr_o), 0);
      chk("R8", "level unchanged", int'(level_o), 0);
   endtask

   task automatic t_full();
      master_reset(3, 1'b0, 1'b1);
      chk("R2", "delayed mode captured", int'(cfg_rtdly_o), 1);
      do_writes(DEPTH);
      chk("R5", "full asserted", int'(full_o), 1);
      chk("R5", "level at depth", int'(level_o), DEPTH);
      chk("R5", "wr_addr wrapped", int'(wr_addr_o), 0);
      do_writes(1);
      chk("R5", "write ignored level", int'(level_o), DEPTH);
      chk("R5", "write ignored addr", int'(wr_addr_o), 0);
   endtask

   task automatic t_delayed_rewind();
      do_reads(4);
      chk("R7", "rd_addr before rewind", int'(rd_addr_o), 4);
      chk("R7", "full cleared by reads", int'(full_o), 0);
      rt_req = 1'b1; rd_en = 1'b1;
      tick();
      chk("R7", "rd_addr rewound", int'(rd_addr_o), 0);
      chk("R7", "level restored", int'(level_o), DEPTH);
      for (int k = 0; k < DLY; k++) begin
         chk("R7", "busy in window", int'(rt_busy_o), 1);
         chk("R7", "empty in window", int'(empty_o), 1);
         chk("R7", "reads blocked", int'(rd_addr_o), 0);
         tick();
      end
      rt_req = 1'b0; rd_en = 1'b0;
      chk("R7", "busy after window", int'(rt_busy_o), 0);
      chk("R7", "empty after window", int'(empty_o), 0);
      chk("R7", "rd_addr after window", int'(rd_addr_o), 0);
      do_reads(1);
      chk("R7", "first replay read", int'(rd_addr_o), 1);
   endtask

   task automatic t_priority();
      do_writes(0);
      mst_rst = 1'b1; ptr_rst = 1'b1; rt_req = 1'b1;
      cfg_off_i = 4'd12; cfg_wide_i = 1'b1; cfg_rtdly_i = 1'b1;
      tick();
      mst_rst = 1'b0; ptr_rst = 1'b0; rt_req = 1'b0;
      chk("R9", "master wins cfg", int'(cfg_off_o), 12);
      chk("R9", "master clears pointers", int'(rd_addr_o) + int'(wr_addr_o), 0);
      chk("R9", "no busy after master", int'(rt_busy_o), 0);
      do_writes(3);
      ptr_rst = 1'b1; rt_req = 1'b1;
      tick();
      ptr_rst = 1'b0; rt_req = 1'b0;
      chk("R9", "partial beats rewind: busy", int'(rt_busy_o), 0);
      chk("R9", "partial beats rewind: level", int'(level_o), 0);
      chk("R9", "cfg kept", int'(cfg_off_o), 12);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      t_reset();
      t_write_read();
      t_zero_rewind();
      t_partial();
      t_empty_rewind();
      t_full();
      t_delayed_rewind();
      t_priority();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule